// File: doc/BRIEF.md
# E1 Gapped Transmit Clock Generator

This block produces the transmit-side system timing for one E1 link when the link is the clock master. A free-running divider on the fast system clock marks bit periods of the 2.048 Mb/s stream. Each bit period yields a one-cycle bit-clock strobe, and the block also drives a framing pulse. Serial data and its signaling companion bit are captured on a selectable edge, and each completed timeslot is handed out as a byte tagged with its timeslot number.

In fractional operation a 32-bit mask names the timeslots whose clock is removed. A further option narrows the removal to the last bit of each named timeslot. Bits that fall in a removed interval never reach the payload. The mask and both gap-mode bits are taken in only at the frame boundary, so a frame is never gapped by a mix of old and new settings. The framing pulse can mark every frame or only the first frame of the 16-frame multiframe count, its active level is selectable, and its update edge is set independently of the data sampling edge.

Top module: `e1_gapclk_gen`

## Requirements
- R1: A bit period is DIV system cycles. The first rising clock edge after reset release is phase 0 of bit 0 of frame 0. A frame is 256 bits (32 timeslots of 8 bits, with bit index 7 last). When fractional mode is off, bclk_en is high for exactly the phase-0 cycle of every bit.
- R2: When fractional mode is on and bit-8-only is off, bclk_en stays low for every bit of a timeslot whose gap_mask bit is 1 (bit n selects timeslot n).
- R3: When fractional mode and bit-8-only are both on, bclk_en stays low only for bit index 7 of each masked timeslot, and all other bits are strobed as in R1.
- R4: Data is sampled at phase 0 when dat_edge_fall=0, or at phase DIV/2 when it is 1. Sampling happens only in ungapped bits. One cycle after the sample of bit index 7, pay_valid pulses with pay_ts set to the timeslot. The first bit of the timeslot appears in pay_data[7]. A fully gapped timeslot yields no pulse, and a gapped bit 8 reads as 0.
- R5: frac_en, bit8_only and gap_mask are captured only in the last cycle of a frame and apply to the whole next frame. After reset the captured values are all zero.
- R6: The internal pulse state is updated at phase 0 (fp_edge_fall=0) or at phase DIV/2 (fp_edge_fall=1). The pulse is active while that update falls in bit 0 of a marked frame, so differing edge selects shift it half a bit against the data.
- R7: fp_type=0 marks every frame. Any other value marks only frame 0 of the 16-frame multiframe count, on which both multiframe kinds are aligned.
- R8: fp_out is the pulse state XOR fp_inv. With fp_inv=1 the pulse is active low.
- R9: pay_sig carries ser_sig captured at the same edges, with the same gapping and bit order as pay_data.
- R10: While rst_n is low, pay_valid is 0 and fp_out shows the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, DIV cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| frac_en | input | 1 | Fractional (gapped) mode request |
| bit8_only | input | 1 | Gap only bit index 7 of masked timeslots |
| gap_mask | input | TS | One gap bit per timeslot |
| fp_edge_fall | input | 1 | Framing pulse update edge: 0 bit start, 1 mid-bit |
| dat_edge_fall | input | 1 | Data sampling edge: 0 bit start, 1 mid-bit |
| fp_type | input | 2 | 0 every frame, otherwise multiframe start |
| fp_inv | input | 1 | Framing pulse active low when 1 |
| ser_data | input | 1 | Serial payload bit |
| ser_sig | input | 1 | Serial signaling bit |
| bclk_en | output | 1 | Gapped bit-clock strobe |
| fp_out | output | 1 | Framing pulse |
| pay_valid | output | 1 | Completed timeslot byte strobe |
| pay_ts | output | TSB | Timeslot number of the byte |
| pay_data | output | TSW | Captured payload byte |
| pay_sig | output | TSW | Captured signaling byte |

## Verification
The bound checker watches the strobe on every cycle. It confirms that the strobe is a single cycle long, that it is present on every bit in full mode, that it is absent in masked timeslots, and that it is present on bits 1 to 7 in bit-8-only mode. It also checks that payload strobes follow only the last bit of a timeslot, that the captured gap settings move only at a frame end, and that the framing output holds between its update edges. Byte contents, the MSB-first order, the zeroed gapped bit 8, the marked frames of each pulse type, and the half-bit offset between edge selects can only be shown by the bench. It runs a reference model over a long sequence of frames, with random payload and junk configuration written mid-frame.

// File: rtl/e1_gapclk_gen.sv
module e1_gapclk_gen #(
  parameter int DIV = 4,
  parameter int TS  = 32,
  parameter int TSW = 8,
  parameter int MFL = 16,
  localparam int TSB = $clog2(TS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frac_en,
  input  logic           bit8_only,
  input  logic [TS-1:0]  gap_mask,
  input  logic           fp_edge_fall,
  input  logic           dat_edge_fall,
  input  logic [1:0]     fp_type,
  input  logic           fp_inv,
  input  logic           ser_data,
  input  logic           ser_sig,
  output logic           bclk_en,
  output logic           fp_out,
  output logic           pay_valid,
  output logic [TSB-1:0] pay_ts,
  output logic [TSW-1:0] pay_data,
  output logic [TSW-1:0] pay_sig
);
  localparam int PW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FBITS = TS * TSW;
  localparam int BW    = $clog2(FBITS);
  localparam int IB    = $clog2(TSW);
  localparam int FW    = $clog2(MFL);
  localparam int HALF  = DIV / 2;

  logic [PW-1:0]  ph;
  logic [BW-1:0]  bpos;
  logic [FW-1:0]  fcnt;
  logic [TS-1:0]  mask_q;
  logic           frac_q, b8_q, fp_q;
  logic [TSW-2:0] sh_d, sh_s;

  wire bit_end   = (ph == PW'(DIV - 1));
  wire frame_end = bit_end && (bpos == BW'(FBITS - 1));
  wire [TSB-1:0] ts = bpos[BW-1:IB];
  wire last_bit  = (bpos[IB-1:0] == IB'(TSW - 1));
  wire ts_gap    = frac_q && mask_q[ts];
  wire bit_gap   = ts_gap && (!b8_q || last_bit);
  wire rise      = (ph == '0);
  wire fall      = (ph == PW'(HALF));
  wire fp_tick   = fp_edge_fall ? fall : rise;
  wire dat_tick  = dat_edge_fall ? fall : rise;
  wire mark      = (bpos == '0) && ((fp_type == 2'd0) || (fcnt == '0));
  wire emit      = dat_tick && last_bit && !(ts_gap && !b8_q);

  assign bclk_en = rise && !bit_gap;
  assign fp_out  = fp_q ^ fp_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= '0;
      bpos   <= '0;
      fcnt   <= '0;
      mask_q <= '0;
      frac_q <= 1'b0;
      b8_q   <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      ph <= bit_end ? '0 : ph + PW'(1);
      if (bit_end)
        bpos <= (bpos == BW'(FBITS - 1)) ? '0 : bpos + BW'(1);
      if (frame_end) begin
        fcnt   <= (fcnt == FW'(MFL - 1)) ? '0 : fcnt + FW'(1);
        mask_q <= gap_mask;
        frac_q <= frac_en;
        b8_q   <= bit8_only;
      end
      if (fp_tick) fp_q <= mark;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_d      <= '0;
      sh_s      <= '0;
      pay_valid <= 1'b0;
      pay_ts    <= '0;
      pay_data  <= '0;
      pay_sig   <= '0;
    end else begin
      pay_valid <= emit;
      if (dat_tick && !bit_gap) begin
        sh_d <= {sh_d[TSW-3:0], ser_data};
        sh_s <= {sh_s[TSW-3:0], ser_sig};
      end
      if (emit) begin
        pay_ts   <= ts;
        pay_data <= {sh_d, ser_data && !bit_gap};
        pay_sig  <= {sh_s, ser_sig && !bit_gap};
      end
    end
  end
endmodule

module e1_gapclk_chk #(
  parameter int DIV = 4,
  parameter int TS  = 32,
  parameter int TSW = 8,
  localparam int TSB   = $clog2(TS),
  localparam int PW    = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int FBITS = TS * TSW,
  localparam int BW    = $clog2(FBITS),
  localparam int IB    = $clog2(TSW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bclk_en,
  input logic           pay_valid,
  input logic [TSB-1:0] pay_ts,
  input logic           fp_out,
  input logic           fp_inv,
  input logic [PW-1:0]  ph,
  input logic [BW-1:0]  bpos,
  input logic           frac_q,
  input logic           b8_q,
  input logic [TS-1:0]  mask_q,
  input logic           fp_tick
);
  wire [TSB-1:0] c_ts = bpos[BW-1:IB];
  wire c_last = (bpos[IB-1:0] == IB'(TSW - 1));

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |=> !bclk_en);
  p_full_every_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_q && ph == '0) |-> bclk_en);
  p_gap_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q && !b8_q && mask_q[c_ts]) |-> !bclk_en);
  p_bit8_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q && b8_q && !c_last && ph == '0) |-> bclk_en);
  p_pay_at_ts_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> ($past(c_last) && pay_ts == $past(c_ts)));
  p_cfg_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph == PW'(DIV - 1) && bpos == BW'(FBITS - 1)) |=> $stable(mask_q));
  p_fp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fp_tick) && $stable(fp_inv)) |-> $stable(fp_out));
endmodule

bind e1_gapclk_gen e1_gapclk_chk #(.DIV(DIV), .TS(TS), .TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .pay_valid(pay_valid),
  .pay_ts(pay_ts), .fp_out(fp_out), .fp_inv(fp_inv), .ph(ph), .bpos(bpos),
  .frac_q(frac_q), .b8_q(b8_q), .mask_q(mask_q), .fp_tick(fp_tick)
);

// File: tb/e1_gapclk_gen_test.sv
module e1_gapclk_gen_test;
  localparam int DIV = 4;
  localparam int FB  = 256;
  localparam int NF  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frac_en = 1'b0, bit8_only = 1'b0;
  logic [31:0] gap_mask = '0;
  logic fp_edge_fall = 1'b0, dat_edge_fall = 1'b0;
  logic [1:0] fp_type = 2'd0;
  logic fp_inv = 1'b0;
  logic ser_data = 1'b0, ser_sig = 1'b0;
  logic bclk_en, fp_out, pay_valid;
  logic [4:0] pay_ts;
  logic [7:0] pay_data, pay_sig;

  always #5 clk = ~clk;

  e1_gapclk_gen uut (
    .clk(clk), .rst_n(rst_n), .frac_en(frac_en), .bit8_only(bit8_only),
    .gap_mask(gap_mask), .fp_edge_fall(fp_edge_fall), .dat_edge_fall(dat_edge_fall),
    .fp_type(fp_type), .fp_inv(fp_inv), .ser_data(ser_data), .ser_sig(ser_sig),
    .bclk_en(bclk_en), .fp_out(fp_out), .pay_valid(pay_valid), .pay_ts(pay_ts),
    .pay_data(pay_data), .pay_sig(pay_sig)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  logic        c_frac [NF+2];
  logic        c_b8   [NF+2];
  logic [31:0] c_mask [NF+2];
  logic        e_fe   [NF+1];
  logic        e_de   [NF+1];
  logic [1:0]  e_ty   [NF+1];
  logic        e_inv  [NF+1];

  logic       m_fp = 1'b0, m_pv = 1'b0;
  logic [6:0] m_shd = '0, m_shs = '0;
  logic [7:0] m_pd = '0, m_ps = '0;
  logic [4:0] m_pts = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string strobe_req(input logic cf, input logic cb);
    return cf ? (cb ? "R3" : "R2") : "R1";
  endfunction

  task automatic step(input int k);
    int ph, bp, fr, fc, ts, bi;
    logic cf, cb, tsg, bg, tick, dt, sd, ss;
    logic [31:0] cm;
    string fq;
    ph = k % DIV; bp = (k / DIV) % FB; fr = k / (DIV * FB); fc = fr % 16;
    cf = (fr > 0) ? c_frac[fr] : 1'b0;
    cb = (fr > 0) ? c_b8[fr]   : 1'b0;
    cm = (fr > 0) ? c_mask[fr] : 32'd0;
    ts = bp / 8; bi = bp % 8;
    tsg = cf && cm[ts];
    bg  = tsg && (!cb || bi == 7);
    // R5: the frame's settings come from the values written late in the previous frame
    chk(strobe_req(cf, cb), 32'(bclk_en), 32'(ph == 0 && !bg));
    fq = (fp_inv ? "R8" : (fp_type != 2'd0 ? "R7" : "R6"));
    chk(fq, 32'(fp_out), 32'(m_fp ^ fp_inv));
    chk("R4", 32'(pay_valid), 32'(m_pv));
    if (m_pv) begin
      chk("R4", 32'(pay_data), 32'(m_pd));
      chk("R4", 32'(pay_ts), 32'(m_pts));
      chk("R9", 32'(pay_sig), 32'(m_ps));
    end
    if (ph == 0) begin
      if (bp == 0) begin
        fp_edge_fall = e_fe[fr]; dat_edge_fall = e_de[fr];
        fp_type = e_ty[fr]; fp_inv = e_inv[fr];
        frac_en = 1'($urandom); bit8_only = 1'($urandom); gap_mask = $urandom;
      end
      if (bp == FB / 2) begin
        frac_en = c_frac[fr+1]; bit8_only = c_b8[fr+1]; gap_mask = c_mask[fr+1];
      end
      ser_data = 1'($urandom); ser_sig = 1'($urandom);
    end
    sd = ser_data; ss = ser_sig;
    tick = fp_edge_fall ? (ph == DIV / 2) : (ph == 0);
    dt   = dat_edge_fall ? (ph == DIV / 2) : (ph == 0);
    if (tick) m_fp = (bp == 0) && (fp_type == 2'd0 || fc == 0);
    m_pv = dt && bi == 7 && !(tsg && !cb);
    if (m_pv) begin
      m_pd = {m_shd, sd && !bg};
      m_ps = {m_shs, ss && !bg};
      m_pts = 5'(ts);
    end
    if (dt && !bg) begin
      m_shd = {m_shd[5:0], sd};
      m_shs = {m_shs[5:0], ss};
    end
  endtask

  initial begin
    void'($urandom(32'd11));
    for (int f = 0; f < NF + 2; f++) begin
      c_frac[f] = 1'($urandom); c_b8[f] = 1'($urandom); c_mask[f] = $urandom;
    end
    c_frac[1] = 1'b0;                                 // R1: mask ignored
    c_frac[2] = 1'b1; c_b8[2] = 1'b0;                 // R2
    c_frac[3] = 1'b1; c_b8[3] = 1'b1;                 // R3
    c_frac[4] = 1'b1; c_b8[4] = 1'b0; c_mask[4] = '1; // R2 all gapped
    c_frac[5] = 1'b1; c_b8[5] = 1'b1; c_mask[5] = '1; // R3 all bit 8 gapped
    c_frac[6] = 1'b1; c_mask[6] = '0;
    for (int f = 0; f <= NF; f++) begin
      e_fe[f] = 1'($urandom); e_de[f] = 1'($urandom);
      e_ty[f] = 2'($urandom); e_inv[f] = 1'($urandom);
    end
    e_fe[0] = 0; e_de[0] = 0; e_ty[0] = 0; e_inv[0] = 0;
    e_fe[1] = 1; e_de[1] = 0; e_ty[1] = 0;
    e_fe[2] = 0; e_de[2] = 1; e_ty[2] = 0;
    e_ty[3] = 2'd1; e_ty[16] = 2'd2; e_ty[17] = 2'd0;

    fp_inv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", 32'(pay_valid), 32'd0);
    chk("R10", 32'(fp_out), 32'd1);
    fp_inv = 1'b0;
    @(negedge clk);
    chk("R10", 32'(fp_out), 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NF * FB * DIV; k++) begin
      step(k);
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule